// File: doc/BRIEF.md
# Co-issue Candidate Screener

This block decides which secondary instructions may ride along with a primary issue slot. One candidate is presented per clock, taken from an instruction-buffer slot of some warp. It carries that warp's identifier, a split identifier, the instruction address, the lane mask cached when the slot was filled, and the class of functional unit it needs. In the same cycle the block reads the split table through a lookup port. The port echoes the warp and split being asked about, and the table returns whether the split still exists, its present address and its present lane mask.

A candidate that survives screening is stored in a small pool. Lanes that have left the split since the slot was cached are dropped, so the stored mask is the intersection of the cached and current masks. The block records the lane count and how many SIMD lane groups (sets) the entry will occupy, and takes those sets from a running budget. Two counters record denials for a wrong unit class and for lack of sets. A start pulse opens a new round: it empties the pool and loads the budget.

The control is a three-state machine. ST_IDLE is the state after reset and ignores candidates. Any start pulse moves it to ST_SCAN, which screens candidates. From ST_SCAN it moves to ST_FULL on the admission that fills the last pool entry. In ST_FULL candidates are dropped, and only a start pulse leaves it, back to ST_SCAN.

Top module: `coi_select`

## Requirements
- R1: A candidate whose split is reported invalid by the lookup port is not admitted and changes neither denial counter.
- R2: A candidate whose address differs from the split's current address is not admitted and changes neither counter.
- R3: The stored lane mask of an admitted entry is the bitwise AND of the cached mask and the current split mask.
- R4: A candidate whose intersected mask is all zero is skipped and changes neither counter.
- R5: The stored active count is the number of set bits in the intersected mask. The stored set count is that number divided by SET_W (default 8) and rounded up.
- R6: A candidate needing more sets than remain in the budget is not admitted, and nosets_cnt_o rises by exactly one.
- R7: A candidate whose warp already has an entry in the pool is skipped and changes neither counter. No two pool entries share a warp.
- R8: A candidate whose unit class differs from req_fu_i is not admitted, and fumis_cnt_o rises by exactly one.
- R9: The checks apply in this order: split valid, address match, duplicate warp, unit class, empty mask, set budget. Only the first check that fails can move a counter.
- R10: Each admission lowers sets_left_o by the entry's set count. Entries fill pool positions 0 upward.
- R11: A start pulse empties the pool and loads avail_sets_i into sets_left_o on the next edge. A candidate presented in the same cycle as the pulse is ignored.
- R12: When all POOL entries (default 4) are taken, candidates are dropped without changing the pool, the budget or the counters.
- R13: After reset the pool is empty and the budget and counters are zero. Candidates that arrive before the first start pulse are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begins a round: clears the pool and loads the budget |
| avail_sets_i | input | SETS_W | Set budget loaded on start |
| req_fu_i | input | FU_W | Unit class required of co-issued instructions |
| cand_valid_i | input | 1 | A candidate is presented this cycle |
| cand_warp_i | input | WID_W | Candidate warp identifier |
| cand_split_i | input | SPL_W | Candidate split identifier |
| cand_pc_i | input | PC_W | Candidate instruction address |
| cand_mask_i | input | LANES | Cached lane mask |
| cand_fu_i | input | FU_W | Candidate unit class |
| lk_warp_o | output | WID_W | Warp being looked up |
| lk_split_o | output | SPL_W | Split being looked up |
| lk_valid_i | input | 1 | Looked-up split currently exists |
| lk_pc_i | input | PC_W | Current address of the split |
| lk_mask_i | input | LANES | Current lane mask of the split |
| pool_valid_o | output | POOL | Occupied pool entries |
| pool_warp_o | output | POOL*WID_W | Warp of each entry |
| pool_split_o | output | POOL*SPL_W | Split of each entry |
| pool_mask_o | output | POOL*LANES | Intersected mask of each entry |
| pool_cnt_o | output | POOL*ACT_W | Active lane count of each entry |
| pool_sets_o | output | POOL*SETS_W | Sets needed by each entry |
| sets_left_o | output | SETS_W | Remaining set budget |
| nosets_cnt_o | output | DCNT_W | Denials for lack of sets |
| fumis_cnt_o | output | DCNT_W | Denials for wrong unit class |

## Verification
Two things can coincide: a start pulse and a candidate in the same cycle, and a candidate that fails several checks at once. The first is provoked by raising start together with a candidate that would otherwise be admitted. The pool must then be empty, the budget must equal the new load, and the same candidate must be admitted on the following cycle. The second is provoked by candidates that are both of the wrong class and short of sets, or both duplicate and of the wrong class. The judge is which counter, if any, moves.

// File: rtl/coi_pkg.sv
package coi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_FULL
    } coi_state_e;

    typedef enum logic [2:0] {
        VD_ADMIT,
        VD_NO_SPLIT,
        VD_PC_MISS,
        VD_DUP_WARP,
        VD_FU_MISS,
        VD_EMPTY,
        VD_NO_SETS
    } coi_verdict_e;

endpackage

// File: rtl/coi_screen.sv
module coi_screen
    import coi_pkg::*;
#(
    parameter int LANES  = 32,
    parameter int SET_W  = 8,
    parameter int POOL   = 4,
    parameter int WID_W  = 5,
    parameter int PC_W   = 16,
    parameter int FU_W   = 2,
    parameter int ACT_W  = 6,
    parameter int SETS_W = 6
) (
    input  logic [WID_W-1:0]      warp_i,
    input  logic [PC_W-1:0]       pc_i,
    input  logic [LANES-1:0]      mask_i,
    input  logic [FU_W-1:0]       fu_i,
    input  logic [FU_W-1:0]       req_fu_i,
    input  logic                  lk_valid_i,
    input  logic [PC_W-1:0]       lk_pc_i,
    input  logic [LANES-1:0]      lk_mask_i,
    input  logic [POOL-1:0]       pool_valid_i,
    input  logic [POOL*WID_W-1:0] pool_warp_i,
    input  logic [SETS_W-1:0]     sets_left_i,
    output coi_verdict_e          verdict_o,
    output logic [LANES-1:0]      eff_mask_o,
    output logic [ACT_W-1:0]      act_cnt_o,
    output logic [SETS_W-1:0]     sets_need_o
);

    localparam int RND_W = ACT_W + 1;

    logic [POOL-1:0] same_warp;
    logic [RND_W-1:0] round_up;

    for (genvar g = 0; g < POOL; g++) begin : g_dup
        assign same_warp[g] = pool_valid_i[g] &&
                              (pool_warp_i[g*WID_W +: WID_W] == warp_i);
    end

    assign eff_mask_o = mask_i & lk_mask_i;

    always_comb begin
        act_cnt_o = '0;
        for (int l = 0; l < LANES; l++) begin
            act_cnt_o = act_cnt_o + ACT_W'(eff_mask_o[l]);
        end
        round_up    = ({1'b0, act_cnt_o} + RND_W'(SET_W - 1)) / RND_W'(SET_W);
        sets_need_o = SETS_W'(round_up);
    end

    always_comb begin
        if (!lk_valid_i)                verdict_o = VD_NO_SPLIT;
        else if (lk_pc_i != pc_i)       verdict_o = VD_PC_MISS;
        else if (|same_warp)            verdict_o = VD_DUP_WARP;
        else if (fu_i != req_fu_i)      verdict_o = VD_FU_MISS;
        else if (eff_mask_o == '0)      verdict_o = VD_EMPTY;
        else if (sets_need_o > sets_left_i) verdict_o = VD_NO_SETS;
        else                            verdict_o = VD_ADMIT;
    end

endmodule

// File: rtl/coi_pool.sv
module coi_pool #(
    parameter int LANES  = 32,
    parameter int POOL   = 4,
    parameter int WID_W  = 5,
    parameter int SPL_W  = 4,
    parameter int ACT_W  = 6,
    parameter int SETS_W = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear_i,
    input  logic                   wr_en_i,
    input  logic [WID_W-1:0]       wr_warp_i,
    input  logic [SPL_W-1:0]       wr_split_i,
    input  logic [LANES-1:0]       wr_mask_i,
    input  logic [ACT_W-1:0]       wr_cnt_i,
    input  logic [SETS_W-1:0]      wr_sets_i,
    output logic                   last_free_o,
    output logic [POOL-1:0]        valid_o,
    output logic [POOL*WID_W-1:0]  warp_o,
    output logic [POOL*SPL_W-1:0]  split_o,
    output logic [POOL*LANES-1:0]  mask_o,
    output logic [POOL*ACT_W-1:0]  cnt_o,
    output logic [POOL*SETS_W-1:0] sets_o
);

    localparam int FILL_W = $clog2(POOL + 1);

    logic [FILL_W-1:0] fill_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        fill_q <= '0;
        else if (clear_i)  fill_q <= '0;
        else if (wr_en_i)  fill_q <= fill_q + 1'b1;
    end

    assign last_free_o = (fill_q == FILL_W'(POOL - 1));

    for (genvar g = 0; g < POOL; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_o[g]                   <= 1'b0;
                warp_o[g*WID_W +: WID_W]     <= '0;
                split_o[g*SPL_W +: SPL_W]    <= '0;
                mask_o[g*LANES +: LANES]     <= '0;
                cnt_o[g*ACT_W +: ACT_W]      <= '0;
                sets_o[g*SETS_W +: SETS_W]   <= '0;
            end else if (clear_i) begin
                valid_o[g]                   <= 1'b0;
            end else if (wr_en_i && fill_q == FILL_W'(g)) begin
                valid_o[g]                   <= 1'b1;
                warp_o[g*WID_W +: WID_W]     <= wr_warp_i;
                split_o[g*SPL_W +: SPL_W]    <= wr_split_i;
                mask_o[g*LANES +: LANES]     <= wr_mask_i;
                cnt_o[g*ACT_W +: ACT_W]      <= wr_cnt_i;
                sets_o[g*SETS_W +: SETS_W]   <= wr_sets_i;
            end
        end
    end

endmodule

// File: rtl/coi_select.sv
module coi_select
    import coi_pkg::*;
#(
    parameter int LANES  = 32,
    parameter int SET_W  = 8,
    parameter int POOL   = 4,
    parameter int WID_W  = 5,
    parameter int SPL_W  = 4,
    parameter int PC_W   = 16,
    parameter int FU_W   = 2,
    parameter int DCNT_W = 16,
    localparam int ACT_W  = $clog2(LANES + 1),
    localparam int SETS_W = $clog2(LANES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [SETS_W-1:0]      avail_sets_i,
    input  logic [FU_W-1:0]        req_fu_i,
    input  logic                   cand_valid_i,
    input  logic [WID_W-1:0]       cand_warp_i,
    input  logic [SPL_W-1:0]       cand_split_i,
    input  logic [PC_W-1:0]        cand_pc_i,
    input  logic [LANES-1:0]       cand_mask_i,
    input  logic [FU_W-1:0]        cand_fu_i,
    output logic [WID_W-1:0]       lk_warp_o,
    output logic [SPL_W-1:0]       lk_split_o,
    input  logic                   lk_valid_i,
    input  logic [PC_W-1:0]        lk_pc_i,
    input  logic [LANES-1:0]       lk_mask_i,
    output logic [POOL-1:0]        pool_valid_o,
    output logic [POOL*WID_W-1:0]  pool_warp_o,
    output logic [POOL*SPL_W-1:0]  pool_split_o,
    output logic [POOL*LANES-1:0]  pool_mask_o,
    output logic [POOL*ACT_W-1:0]  pool_cnt_o,
    output logic [POOL*SETS_W-1:0] pool_sets_o,
    output logic [SETS_W-1:0]      sets_left_o,
    output logic [DCNT_W-1:0]      nosets_cnt_o,
    output logic [DCNT_W-1:0]      fumis_cnt_o
);

    coi_state_e        state_q, state_d;
    coi_verdict_e      verdict;
    logic [LANES-1:0]  eff_mask;
    logic [ACT_W-1:0]  act_cnt;
    logic [SETS_W-1:0] sets_need;
    logic              last_free;
    logic              judging, admit, deny_sets, deny_fu;

    assign lk_warp_o  = cand_warp_i;
    assign lk_split_o = cand_split_i;

    coi_screen #(
        .LANES(LANES), .SET_W(SET_W), .POOL(POOL), .WID_W(WID_W),
        .PC_W(PC_W), .FU_W(FU_W), .ACT_W(ACT_W), .SETS_W(SETS_W)
    ) u_screen (
        .warp_i      (cand_warp_i),
        .pc_i        (cand_pc_i),
        .mask_i      (cand_mask_i),
        .fu_i        (cand_fu_i),
        .req_fu_i    (req_fu_i),
        .lk_valid_i  (lk_valid_i),
        .lk_pc_i     (lk_pc_i),
        .lk_mask_i   (lk_mask_i),
        .pool_valid_i(pool_valid_o),
        .pool_warp_i (pool_warp_o),
        .sets_left_i (sets_left_o),
        .verdict_o   (verdict),
        .eff_mask_o  (eff_mask),
        .act_cnt_o   (act_cnt),
        .sets_need_o (sets_need)
    );

    coi_pool #(
        .LANES(LANES), .POOL(POOL), .WID_W(WID_W), .SPL_W(SPL_W),
        .ACT_W(ACT_W), .SETS_W(SETS_W)
    ) u_pool (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (start_i),
        .wr_en_i    (admit),
        .wr_warp_i  (cand_warp_i),
        .wr_split_i (cand_split_i),
        .wr_mask_i  (eff_mask),
        .wr_cnt_i   (act_cnt),
        .wr_sets_i  (sets_need),
        .last_free_o(last_free),
        .valid_o    (pool_valid_o),
        .warp_o     (pool_warp_o),
        .split_o    (pool_split_o),
        .mask_o     (pool_mask_o),
        .cnt_o      (pool_cnt_o),
        .sets_o     (pool_sets_o)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = ST_SCAN;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_SCAN: if (admit && last_free) state_d = ST_FULL;
                ST_FULL: state_d = ST_FULL;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs of the machine
    always_comb begin
        judging   = 1'b0;
        unique case (state_q)
            ST_IDLE: judging = 1'b0;
            ST_SCAN: judging = cand_valid_i && !start_i;
            ST_FULL: judging = 1'b0;
            default: judging = 1'b0;
        endcase
        admit     = judging && (verdict == VD_ADMIT);
        deny_sets = judging && (verdict == VD_NO_SETS);
        deny_fu   = judging && (verdict == VD_FU_MISS);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sets_left_o  <= '0;
            nosets_cnt_o <= '0;
            fumis_cnt_o  <= '0;
        end else begin
            if (start_i)    sets_left_o <= avail_sets_i;
            else if (admit) sets_left_o <= sets_left_o - sets_need;
            if (deny_sets)  nosets_cnt_o <= nosets_cnt_o + 1'b1;
            if (deny_fu)    fumis_cnt_o  <= fumis_cnt_o + 1'b1;
        end
    end

endmodule

// File: rtl/coi_select_chk.sv
module coi_select_chk #(
    parameter int LANES  = 32,
    parameter int POOL   = 4,
    parameter int WID_W  = 5,
    parameter int ACT_W  = 6,
    parameter int SETS_W = 6,
    parameter int DCNT_W = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start_i,
    input logic [LANES-1:0]      cand_mask_i,
    input logic [LANES-1:0]      lk_mask_i,
    input logic [POOL-1:0]       pool_valid_o,
    input logic [POOL*WID_W-1:0] pool_warp_o,
    input logic [POOL*LANES-1:0] pool_mask_o,
    input logic [POOL*ACT_W-1:0] pool_cnt_o,
    input logic [SETS_W-1:0]     sets_left_o,
    input logic [DCNT_W-1:0]     nosets_cnt_o,
    input logic [DCNT_W-1:0]     fumis_cnt_o
);

    int               fill, fill_q;
    logic [LANES-1:0] and_q, newest_mask;
    logic [ACT_W-1:0] newest_cnt;
    logic             dup_seen;

    always_comb begin
        fill = $countones(pool_valid_o);
        newest_mask = '0;
        newest_cnt  = '0;
        for (int e = 0; e < POOL; e++) begin
            if (e == fill - 1) begin
                newest_mask = pool_mask_o[e*LANES +: LANES];
                newest_cnt  = pool_cnt_o[e*ACT_W +: ACT_W];
            end
        end
        dup_seen = 1'b0;
        for (int a = 0; a < POOL; a++) begin
            for (int b = a + 1; b < POOL; b++) begin
                if (pool_valid_o[a] && pool_valid_o[b] &&
                    pool_warp_o[a*WID_W +: WID_W] == pool_warp_o[b*WID_W +: WID_W])
                    dup_seen = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q <= 0;
            and_q  <= '0;
        end else begin
            fill_q <= fill;
            and_q  <= cand_mask_i & lk_mask_i;
        end
    end

    AST_NEW_ENTRY_MASK: assert property (@(posedge clk) disable iff (!rst_n) (fill == fill_q + 1) |-> (newest_mask == and_q)) else $error("new entry mask"); // R3
    AST_NEW_ENTRY_COUNT: assert property (@(posedge clk) disable iff (!rst_n) (fill == fill_q + 1) |-> (newest_cnt == ACT_W'($countones(newest_mask)))) else $error("new entry count"); // R5
    AST_NOSETS_STEP: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> (nosets_cnt_o == $past(nosets_cnt_o) || nosets_cnt_o == $past(nosets_cnt_o) + 1'b1)) else $error("nosets step"); // R6
    AST_NO_DUP_WARP: assert property (@(posedge clk) disable iff (!rst_n) !dup_seen) else $error("duplicate warp"); // R7
    AST_ONE_COUNTER: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> !(nosets_cnt_o != $past(nosets_cnt_o) && fumis_cnt_o != $past(fumis_cnt_o))) else $error("two counters"); // R9
    AST_BUDGET_FALLS: assert property (@(posedge clk) disable iff (!rst_n) !start_i |=> (sets_left_o <= $past(sets_left_o))) else $error("budget grew"); // R10
    AST_START_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) start_i |=> (pool_valid_o == '0)) else $error("start left entries"); // R11
    AST_POOL_PREFIX: assert property (@(posedge clk) disable iff (!rst_n) ((pool_valid_o & POOL'(pool_valid_o + 1'b1)) == '0)) else $error("pool holes"); // R12

endmodule

bind coi_select coi_select_chk #(
    .LANES(LANES), .POOL(POOL), .WID_W(WID_W),
    .ACT_W(ACT_W), .SETS_W(SETS_W), .DCNT_W(DCNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .cand_mask_i (cand_mask_i),
    .lk_mask_i   (lk_mask_i),
    .pool_valid_o(pool_valid_o),
    .pool_warp_o (pool_warp_o),
    .pool_mask_o (pool_mask_o),
    .pool_cnt_o  (pool_cnt_o),
    .sets_left_o (sets_left_o),
    .nosets_cnt_o(nosets_cnt_o),
    .fumis_cnt_o (fumis_cnt_o)
);

// File: tb/coi_select_test.sv
module coi_select_test;

    localparam int LANES = 32, SET_W = 8, POOL = 4, WID_W = 5, SPL_W = 4;
    localparam int PC_W = 16, FU_W = 2, DCNT_W = 16, ACT_W = 6, SETS_W = 6;

    typedef struct packed {
        logic        st;
        logic [5:0]  avail;
        logic [4:0]  warp;
        logic [15:0] pc;
        logic [31:0] mask;
        logic [1:0]  fu;
        logic        lkv;
        logic [15:0] lkpc;
        logic [31:0] lkmask;
        logic [2:0]  fill;
        logic [5:0]  left;
        logic        dn;
        logic        df;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 6'd6,  5'd0,  16'h0,   32'h0,        2'd0, 1'b0, 16'h0,   32'h0,        3'd0, 6'd6,  1'b0, 1'b0, 8'd11}, // R11 start
        '{1'b0, 6'd0,  5'd3,  16'h100, 32'hFFFFFFFF, 2'd1, 1'b1, 16'h100, 32'h000000FF, 3'd1, 6'd5,  1'b0, 1'b0, 8'd3},  // R3 trim
        '{1'b0, 6'd0,  5'd3,  16'h100, 32'hFFFFFFFF, 2'd1, 1'b1, 16'h100, 32'h000000FF, 3'd1, 6'd5,  1'b0, 1'b0, 8'd7},  // R7 dup
        '{1'b0, 6'd0,  5'd4,  16'h100, 32'hFFFFFFFF, 2'd1, 1'b0, 16'h100, 32'hFFFFFFFF, 3'd1, 6'd5,  1'b0, 1'b0, 8'd1},  // R1
        '{1'b0, 6'd0,  5'd4,  16'h100, 32'hFFFFFFFF, 2'd1, 1'b1, 16'h104, 32'hFFFFFFFF, 3'd1, 6'd5,  1'b0, 1'b0, 8'd2},  // R2
        '{1'b0, 6'd0,  5'd4,  16'h100, 32'hFFFFFFFF, 2'd2, 1'b1, 16'h100, 32'hFFFFFFFF, 3'd1, 6'd5,  1'b0, 1'b1, 8'd8},  // R8
        '{1'b0, 6'd0,  5'd4,  16'h100, 32'h0000FF00, 2'd1, 1'b1, 16'h100, 32'h00FF0000, 3'd1, 6'd5,  1'b0, 1'b0, 8'd4},  // R4
        '{1'b0, 6'd0,  5'd4,  16'h100, 32'hFFFFFFFF, 2'd1, 1'b1, 16'h100, 32'hFFFFFFFF, 3'd2, 6'd1,  1'b0, 1'b0, 8'd5},  // R5 32 lanes
        '{1'b0, 6'd0,  5'd5,  16'h200, 32'h00000003, 2'd1, 1'b1, 16'h200, 32'h00000007, 3'd3, 6'd0,  1'b0, 1'b0, 8'd5},  // R5 round up
        '{1'b0, 6'd0,  5'd6,  16'h200, 32'h00000001, 2'd1, 1'b1, 16'h200, 32'h00000001, 3'd3, 6'd0,  1'b1, 1'b0, 8'd6},  // R6
        '{1'b0, 6'd0,  5'd6,  16'h200, 32'h00000001, 2'd0, 1'b1, 16'h200, 32'h00000001, 3'd3, 6'd0,  1'b0, 1'b1, 8'd9},  // R9 fu first
        '{1'b0, 6'd0,  5'd3,  16'h200, 32'h00000001, 2'd0, 1'b1, 16'h200, 32'h00000001, 3'd3, 6'd0,  1'b0, 1'b0, 8'd9},  // R9 dup first
        '{1'b1, 6'd32, 5'd0,  16'h0,   32'h0,        2'd0, 1'b0, 16'h0,   32'h0,        3'd0, 6'd32, 1'b0, 1'b0, 8'd11}, // R11
        '{1'b0, 6'd0,  5'd1,  16'h300, 32'h000001FF, 2'd1, 1'b1, 16'h300, 32'hFFFFFFFF, 3'd1, 6'd30, 1'b0, 1'b0, 8'd10}, // R10
        '{1'b0, 6'd0,  5'd2,  16'h300, 32'h000001FF, 2'd1, 1'b1, 16'h300, 32'hFFFFFFFF, 3'd2, 6'd28, 1'b0, 1'b0, 8'd10},
        '{1'b0, 6'd0,  5'd3,  16'h300, 32'h000001FF, 2'd1, 1'b1, 16'h300, 32'hFFFFFFFF, 3'd3, 6'd26, 1'b0, 1'b0, 8'd10},
        '{1'b0, 6'd0,  5'd4,  16'h300, 32'h000001FF, 2'd1, 1'b1, 16'h300, 32'hFFFFFFFF, 3'd4, 6'd24, 1'b0, 1'b0, 8'd10},
        '{1'b0, 6'd0,  5'd7,  16'h300, 32'h000001FF, 2'd1, 1'b1, 16'h300, 32'hFFFFFFFF, 3'd4, 6'd24, 1'b0, 1'b0, 8'd12}, // R12
        '{1'b0, 6'd0,  5'd8,  16'h300, 32'h000001FF, 2'd0, 1'b1, 16'h300, 32'hFFFFFFFF, 3'd4, 6'd24, 1'b0, 1'b0, 8'd12}, // R12
        '{1'b1, 6'd8,  5'd0,  16'h0,   32'h0,        2'd0, 1'b0, 16'h0,   32'h0,        3'd0, 6'd8,  1'b0, 1'b0, 8'd11}, // R11
        '{1'b0, 6'd0,  5'd9,  16'h400, 32'h0000F0F0, 2'd1, 1'b1, 16'h400, 32'h0000FFFF, 3'd1, 6'd7,  1'b0, 1'b0, 8'd5},
        '{1'b0, 6'd0,  5'd10, 16'h400, 32'hFFFFFFFF, 2'd1, 1'b1, 16'h400, 32'hFFFFFFFF, 3'd2, 6'd3,  1'b0, 1'b0, 8'd10},
        '{1'b0, 6'd0,  5'd11, 16'h400, 32'hFFFFFFFF, 2'd1, 1'b1, 16'h400, 32'hFFFFFFFF, 3'd2, 6'd3,  1'b1, 1'b0, 8'd6},  // R6
        '{1'b0, 6'd0,  5'd11, 16'h400, 32'h00FF00FF, 2'd1, 1'b1, 16'h400, 32'hFFFFFFFF, 3'd3, 6'd1,  1'b0, 1'b0, 8'd10}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [SETS_W-1:0] avail_sets_i = '0;
    logic [FU_W-1:0] req_fu_i = 2'd1;
    logic cand_valid_i = 1'b0;
    logic [WID_W-1:0] cand_warp_i = '0;
    logic [SPL_W-1:0] cand_split_i = '0;
    logic [PC_W-1:0] cand_pc_i = '0;
    logic [LANES-1:0] cand_mask_i = '0;
    logic [FU_W-1:0] cand_fu_i = '0;
    logic [WID_W-1:0] lk_warp_o;
    logic [SPL_W-1:0] lk_split_o;
    logic lk_valid_i = 1'b0;
    logic [PC_W-1:0] lk_pc_i = '0;
    logic [LANES-1:0] lk_mask_i = '0;
    logic [POOL-1:0] pool_valid_o;
    logic [POOL*WID_W-1:0] pool_warp_o;
    logic [POOL*SPL_W-1:0] pool_split_o;
    logic [POOL*LANES-1:0] pool_mask_o;
    logic [POOL*ACT_W-1:0] pool_cnt_o;
    logic [POOL*SETS_W-1:0] pool_sets_o;
    logic [SETS_W-1:0] sets_left_o;
    logic [DCNT_W-1:0] nosets_cnt_o, fumis_cnt_o;

    int checks = 0, fails = 0;
    int exp_dn = 0, exp_df = 0, prev_fill = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    coi_select uut (.*);

    task automatic chk(input int req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int pop(input logic [31:0] m);
        int n = 0;
        for (int l = 0; l < 32; l++) n += int'(m[l]);
        return n;
    endfunction

    task automatic drive(input logic st, input logic [5:0] av, input logic [4:0] w, input logic [15:0] pc,
                         input logic [31:0] m, input logic [1:0] fu, input logic lkv,
                         input logic [15:0] lkpc, input logic [31:0] lkm, input logic cv);
        start_i = st; avail_sets_i = av; cand_valid_i = cv;
        cand_warp_i = w; cand_split_i = w[3:0]; cand_pc_i = pc; cand_mask_i = m; cand_fu_i = fu;
        lk_valid_i = lkv; lk_pc_i = lkpc; lk_mask_i = lkm;
    endtask

    task automatic check_state(input int req, input int fill, input int left);
        chk(req, "pool fill", 64'($countones(pool_valid_o)), 64'(fill));
        chk(req, "sets left", 64'(sets_left_o), 64'(left));
        chk(req, "nosets count", 64'(nosets_cnt_o), 64'(exp_dn));
        chk(req, "fu-miss count", 64'(fumis_cnt_o), 64'(exp_df));
    endtask

    task automatic check_newest(input int req, input int idx, input logic [4:0] w,
                                input logic [31:0] m, input logic [31:0] lkm);
        int n;
        n = pop(m & lkm);
        chk(req, "entry warp", 64'(pool_warp_o[idx*WID_W +: WID_W]), 64'(w));
        chk(3, "entry mask R3", 64'(pool_mask_o[idx*LANES +: LANES]), 64'(m & lkm));
        chk(5, "entry count R5", 64'(pool_cnt_o[idx*ACT_W +: ACT_W]), 64'(n));
        chk(5, "entry sets R5", 64'(pool_sets_o[idx*SETS_W +: SETS_W]), 64'((n + SET_W - 1) / SET_W));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R13: reset state
        check_state(13, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_state(13, 0, 0);
        // R13: candidate before first start is ignored, even a wrong class
        drive(1'b0, 6'd0, 5'd2, 16'h10, 32'hF, 2'd0, 1'b1, 16'h10, 32'hF, 1'b1);
        @(negedge clk);
        check_state(13, 0, 0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].st, VEC[i].avail, VEC[i].warp, VEC[i].pc, VEC[i].mask, VEC[i].fu,
                  VEC[i].lkv, VEC[i].lkpc, VEC[i].lkmask, !VEC[i].st);
            @(negedge clk);
            exp_dn += int'(VEC[i].dn);
            exp_df += int'(VEC[i].df);
            check_state(int'(VEC[i].req), int'(VEC[i].fill), int'(VEC[i].left));
            if (int'(VEC[i].fill) == prev_fill + 1)
                check_newest(int'(VEC[i].req), prev_fill, VEC[i].warp, VEC[i].mask, VEC[i].lkmask);
            prev_fill = int'(VEC[i].fill);
        end

        // R11: start and a good candidate together; candidate ignored
        drive(1'b1, 6'd10, 5'd12, 16'h500, 32'h1, 2'd1, 1'b1, 16'h500, 32'h1, 1'b1);
        @(negedge clk);
        check_state(11, 0, 10);
        // same candidate alone next cycle is admitted
        drive(1'b0, 6'd0, 5'd12, 16'h500, 32'h1, 2'd1, 1'b1, 16'h500, 32'h1, 1'b1);
        @(negedge clk);
        check_state(11, 1, 9);
        check_newest(11, 0, 5'd12, 32'h1, 32'h1);
        drive(1'b0, 6'd0, 5'd0, 16'h0, 32'h0, 2'd0, 1'b0, 16'h0, 32'h0, 1'b0);
        @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL R13 watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule